// File: doc/BRIEF.md
# Stop-Mode Clock and Wakeup Controller

This block sequences a small microcontroller clock generator into and out of a low-power stop state. A free-running prescaler counter produces a one-cycle periodic tick while the core runs. A CPU stop request parks the block in stop. The counter is cleared on that entry and then serves as the timer for the wakeup recovery delay. An enabled wakeup interrupt ends stop, and the exit follows one of four styles chosen by three configuration bits. Those bits are captured at the moment stop is entered.

With pseudo-stop selected, the oscillator keeps running and the core resumes immediately. With the delay bit set, the oscillator restarts and the core clock is held off for one full counter period. With both the delay bit and the limp-disable bit clear, the core resumes at once on a backup clock, then moves back to the oscillator after one full counter period. With the delay bit clear and the limp-disable bit set, the core resumes at once on an externally driven clock. A single state register drives both the oscillator enable and the stop indication. As a result, a tick that lands on the same cycle as the stop request cannot leave the oscillator off while the stop indication is low.

Top module: `stop_wake`

## Requirements
- R1: While `rstN` or `porN` is low (both active low), `oscEn`=1, `stopInd`=0, `clkSel`=0 and `tick`=0, and the counter is cleared. The first `tick` after release comes after exactly 2^CNT_W−1 rising edges.
- R2: In run state, `tick` is high for exactly one cycle, once every 2^CNT_W cycles. It is never high while `stopInd`=1 or `clkSel`=1.
- R3: In run state, a `stopReq` sampled high at a rising edge sets `stopInd`=1 from that edge on. When pseudo-stop is not selected, it also drops `oscEn` to 0.
- R4: `oscEn`=0 always implies `stopInd`=1. Stop entry works the same when `stopReq` coincides with the cycle in which `tick` is high.
- R5: In stop, `wakeIrq` has no effect while `wakeEn`=0. The block stays stopped until `wakeIrq` and `wakeEn` are both sampled high.
- R6: With the delay bit captured as 1 and pseudo-stop as 0, `oscEn` becomes 1 at the wake edge. `stopInd` then stays 1 for exactly 2^CNT_W samples, counting from the wake edge, and `clkSel` stays 0.
- R7: With pseudo-stop captured as 1, `oscEn` stays 1 throughout stop. At the wake edge `stopInd` returns to 0, and pseudo-stop takes precedence over the delay bit.
- R8: With the delay bit and limp-disable both captured as 0, at the wake edge `stopInd`=0 and `clkSel`=1 (1 = backup clock). `clkSel` stays 1 for exactly 2^CNT_W samples, with `oscEn`=1 throughout.
- R9: With the delay bit captured as 0 and limp-disable as 1, at the wake edge `stopInd`=0 and `clkSel`=0.
- R10: The exit-style bits are captured at the stop-entry edge. Changing them during stop alters neither the stop outputs nor the exit behaviour.
- R11: `stopReq` is ignored outside run state, including during recovery and the backup-clock interval.
- R12: On every return to run state the counter restarts from zero. The first `tick` follows 2^CNT_W−1 edges after the return edge, whatever the counter phase was at stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also stands for the always-available recovery clock |
| rstN | input | 1 | Reset, active low |
| porN | input | 1 | Power-on reset, active low |
| stopReq | input | 1 | Stop request from the CPU |
| wakeIrq | input | 1 | Wakeup interrupt |
| wakeEn | input | 1 | Enable for the wakeup interrupt |
| dlyEn | input | 1 | Exit-style bit: wait for the recovery delay |
| pseudoStop | input | 1 | Exit-style bit: keep the oscillator running in stop |
| limpOff | input | 1 | Exit-style bit: disable the backup-clock exit |
| oscEn | output | 1 | Oscillator enable |
| stopInd | output | 1 | Internal stop indication (1 = core clock halted) |
| clkSel | output | 1 | Clock select (0 = oscillator, 1 = backup clock) |
| tick | output | 1 | Periodic one-cycle tick |

## Verification
The bench builds the block with CNT_W=4, which gives a 16-cycle tick period. This short period lets one run place the stop request on every counter phase, including the tick cycle itself. It also lets the bench measure each recovery window and backup-clock window to the exact cycle, so that none of the waits runs to thousands of cycles. At that size the bench can also confirm, after each sweep point, that the counter restarts at zero on the return to run.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOP    = 2'd1,
    ST_RECOVER = 2'd2,
    ST_LIMP    = 2'd3
  } phase_t;

  // exit style captured at stop entry
  typedef struct packed {
    logic pseudo;
    logic dly;
    logic limpOff;
  } exit_mode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic modeLoad;
    logic tickEn;
  } dp_strobe_t;

endpackage

// File: rtl/stop_wake_dp.sv
module stop_wake_dp
  import stop_wake_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       arstN,
  input  dp_strobe_t strb,
  input  exit_mode_t cfgIn,
  output exit_mode_t mode,
  output logic       cntFull,
  output logic       tick
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  // prescaler: free-running, doubles as recovery timer
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)           cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             mode <= '0;
    else if (strb.modeLoad) mode <= cfgIn;
  end

  assign cntFull = (cnt == CNT_MAX);
  assign tick    = cntFull & strb.tickEn;

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       stopReq,
  input  logic       wakeIrq,
  input  logic       wakeEn,
  input  logic       cntFull,
  input  exit_mode_t mode,
  output dp_strobe_t strb,
  output logic       oscEn,
  output logic       stopInd,
  output logic       clkSel
);

  phase_t phase, phaseNext;
  logic   wakeHit;

  assign wakeHit = wakeIrq & wakeEn;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) phase <= ST_RUN;
    else        phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      ST_RUN: begin
        strb.tickEn = 1'b1;
        // a coincident tick changes nothing: entry wins, counter clears
        if (stopReq) begin
          phaseNext     = ST_STOP;
          strb.cntClr   = 1'b1;
          strb.modeLoad = 1'b1;
        end
      end
      ST_STOP: begin
        strb.cntClr = 1'b1;
        if (wakeHit) begin
          if (mode.pseudo)        phaseNext = ST_RUN;
          else if (mode.dly)      phaseNext = ST_RECOVER;
          else if (!mode.limpOff) phaseNext = ST_LIMP;
          else                    phaseNext = ST_RUN;
        end
      end
      ST_RECOVER: if (cntFull) phaseNext = ST_RUN;
      ST_LIMP:    if (cntFull) phaseNext = ST_RUN;
      default:    phaseNext = ST_RUN;
    endcase
  end

  // both stop-related outputs decode the same state register
  assign oscEn   = (phase != ST_STOP) | mode.pseudo;
  assign stopInd = (phase == ST_STOP) | (phase == ST_RECOVER);
  assign clkSel  = (phase == ST_LIMP);

endmodule

// File: rtl/stop_wake.sv
module stop_wake
  import stop_wake_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic porN,
  input  logic stopReq,
  input  logic wakeIrq,
  input  logic wakeEn,
  input  logic dlyEn,
  input  logic pseudoStop,
  input  logic limpOff,
  output logic oscEn,
  output logic stopInd,
  output logic clkSel,
  output logic tick
);

  logic       arstN;
  dp_strobe_t strb;
  exit_mode_t mode;
  exit_mode_t cfgIn;
  logic       cntFull;

  assign arstN = rstN & porN;
  assign cfgIn = '{pseudo: pseudoStop, dly: dlyEn, limpOff: limpOff};

  stop_wake_ctrl uCtrl (
    .clk     (clk),
    .arstN   (arstN),
    .stopReq (stopReq),
    .wakeIrq (wakeIrq),
    .wakeEn  (wakeEn),
    .cntFull (cntFull),
    .mode    (mode),
    .strb    (strb),
    .oscEn   (oscEn),
    .stopInd (stopInd),
    .clkSel  (clkSel)
  );

  stop_wake_dp #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .arstN   (arstN),
    .strb    (strb),
    .cfgIn   (cfgIn),
    .mode    (mode),
    .cntFull (cntFull),
    .tick    (tick)
  );

endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk (
  input logic clk,
  input logic rstN,
  input logic porN,
  input logic stopReq,
  input logic wakeEn,
  input logic oscEn,
  input logic stopInd,
  input logic clkSel,
  input logic tick
);

  // R4
  osc_off_stop_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !oscEn |-> stopInd);

  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (!stopInd && !clkSel && stopReq) |=> stopInd);

  // R2
  tick_run_only_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    tick |-> (!stopInd && !clkSel));

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    tick |=> !tick);

  // R5
  wake_masked_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (stopInd && !oscEn && !wakeEn) |=> (stopInd && !oscEn));

  // R8
  limp_clock_chk: assert property (@(posedge clk) disable iff (!rstN || !porN)
    clkSel |-> (oscEn && !stopInd));

endmodule

bind stop_wake stop_wake_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .porN    (porN),
  .stopReq (stopReq),
  .wakeEn  (wakeEn),
  .oscEn   (oscEn),
  .stopInd (stopInd),
  .clkSel  (clkSel),
  .tick    (tick)
);

// File: tb/stop_wake_test.sv
`timescale 1ns/1ps
module stop_wake_test;

  localparam int W   = 4;
  localparam int PER = 1 << W;
  localparam int MAX = PER - 1;

  logic clk = 1'b0;
  logic rstN, porN, stopReq, wakeIrq, wakeEn, dlyEn, pseudoStop, limpOff;
  logic oscEn, stopInd, clkSel, tick;
  int   total = 0;
  int   failed = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  stop_wake #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .porN(porN), .stopReq(stopReq),
    .wakeIrq(wakeIrq), .wakeEn(wakeEn), .dlyEn(dlyEn),
    .pseudoStop(pseudoStop), .limpOff(limpOff),
    .oscEn(oscEn), .stopInd(stopInd), .clkSel(clkSel), .tick(tick)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setMode(input logic d, input logic p, input logic l);
    dlyEn = d; pseudoStop = p; limpOff = l;
  endtask

  task automatic doReset();
    stopReq = 0; wakeIrq = 0; wakeEn = 1; setMode(1, 0, 1);
    rstN = 0; porN = 1;
    step(); step();
    rstN = 1;
  endtask

  task automatic enterStop();
    stopReq = 1; step(); stopReq = 0;
  endtask

  task automatic wakeUp();
    wakeIrq = 1; step(); wakeIrq = 0;
  endtask

  // number of samples (current included) for which stopInd stays high
  task automatic countStop(output int n);
    n = 0;
    while (stopInd && n < 4 * PER) begin n++; step(); end
  endtask

  task automatic countLimp(output int n);
    n = 0;
    while (clkSel && n < 4 * PER) begin n++; step(); end
  endtask

  // edges until tick seen
  task automatic edgesToTick(output int n);
    n = 0;
    while (!tick && n < 4 * PER) begin n++; step(); end
  endtask

  task automatic testReset();
    int n;
    stopReq = 0; wakeIrq = 0; wakeEn = 1; setMode(1, 0, 1);
    rstN = 0; porN = 1; step();
    checkEq("R1 oscEn in reset", oscEn, 1);
    checkEq("R1 stopInd in reset", stopInd, 0);
    checkEq("R1 clkSel in reset", clkSel, 0);
    checkEq("R1 tick in reset", tick, 0);
    rstN = 1;
    edgesToTick(n);
    checkEq("R1 first tick after reset", n, MAX);
    step(); step(); step(); step(); step();
    porN = 0; step(); porN = 1;
    edgesToTick(n);
    checkEq("R1 first tick after power-on reset", n, MAX);
  endtask

  task automatic testTickPeriod();
    int n;
    doReset();
    edgesToTick(n);
    for (int k = 0; k < 3; k++) begin
      step();
      checkEq("R2 tick width one cycle", tick, 0);
      edgesToTick(n);
      checkEq("R2 tick period", n + 1, PER);
    end
  endtask

  task automatic testSweep();
    int n;
    for (int p = 0; p < PER; p++) begin
      doReset();
      for (int k = 0; k < p; k++) step();
      checkEq($sformatf("R4 tick at phase %0d", p), tick, (p == MAX) ? 1 : 0);
      enterStop();
      checkEq($sformatf("R3 stopInd after entry phase %0d", p), stopInd, 1);
      checkEq($sformatf("R4 oscEn after entry phase %0d", p), oscEn, 0);
      step(); step(); step();
      checkEq($sformatf("R4 still stopped phase %0d", p), {oscEn, stopInd}, 2'b01);
      wakeUp();
      checkEq($sformatf("R6 oscEn on wake phase %0d", p), oscEn, 1);
      countStop(n);
      checkEq($sformatf("R6 recovery length phase %0d", p), n, PER);
      checkEq($sformatf("R6 clkSel after recovery phase %0d", p), clkSel, 0);
      edgesToTick(n);
      checkEq($sformatf("R12 tick after return phase %0d", p), n, MAX);
    end
  endtask

  task automatic testWakeMask();
    int bad = 0;
    doReset();
    enterStop();
    wakeEn = 0; wakeIrq = 1;
    for (int k = 0; k < 2 * PER; k++) begin
      step();
      if (!(stopInd && !oscEn)) bad++;
    end
    checkEq("R5 masked wake ignored", bad, 0);
    wakeEn = 1; step(); wakeIrq = 0;
    checkEq("R5 enabled wake exits", oscEn, 1);
  endtask

  task automatic testPseudo();
    doReset();
    setMode(1, 1, 1);
    enterStop();
    checkEq("R7 stopInd in pseudo stop", stopInd, 1);
    step(); step();
    checkEq("R7 oscEn kept in pseudo stop", oscEn, 1);
    wakeUp();
    checkEq("R7 immediate exit", {stopInd, clkSel, oscEn}, 3'b001);
  endtask

  task automatic testLimp();
    int n;
    doReset();
    setMode(0, 0, 0);
    enterStop();
    checkEq("R8 oscEn off in stop", oscEn, 0);
    wakeUp();
    checkEq("R8 on backup clock", {stopInd, clkSel, oscEn}, 3'b011);
    countLimp(n);
    checkEq("R8 backup clock length", n, PER);
    checkEq("R8 back on oscillator", {stopInd, clkSel, oscEn}, 3'b001);
  endtask

  task automatic testDirect();
    doReset();
    setMode(0, 0, 1);
    enterStop();
    checkEq("R9 oscEn off in stop", oscEn, 0);
    wakeUp();
    checkEq("R9 direct exit", {stopInd, clkSel, oscEn}, 3'b001);
  endtask

  task automatic testCapture();
    int n;
    doReset();
    setMode(1, 0, 1);
    enterStop();
    setMode(0, 1, 0);
    step(); step();
    checkEq("R10 oscEn unaffected by mode change", oscEn, 0);
    wakeUp();
    checkEq("R10 captured delay exit", {stopInd, clkSel}, 2'b10);
    countStop(n);
    checkEq("R10 captured recovery length", n, PER);
  endtask

  task automatic testIgnoreReq();
    int n;
    doReset();
    enterStop();
    wakeUp();
    step(); step();
    stopReq = 1; step(); stopReq = 0;
    countStop(n);
    checkEq("R11 recovery length with stray request", n + 3, PER);
    step(); step();
    checkEq("R11 running after recovery", {stopInd, oscEn}, 2'b01);
    setMode(0, 0, 0);
    enterStop();
    wakeUp();
    step();
    stopReq = 1; step(); stopReq = 0;
    countLimp(n);
    checkEq("R11 backup length with stray request", n + 2, PER);
    checkEq("R11 running after backup clock", {stopInd, clkSel, oscEn}, 3'b001);
  endtask

  initial begin
    testReset();
    testTickPeriod();
    testSweep();
    testWakeMask();
    testPseudo();
    testLimp();
    testDirect();
    testCapture();
    testIgnoreReq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      total++; failed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule